// File: doc/BRIEF.md
# Exponent-Mantissa Baud Rate Generator

This block derives the timing pulses of an asynchronous serial channel from a fixed reference clock. A 10-bit divisor word holds a 6-bit mantissa N and a 4-bit exponent M. The block emits an oversampling pulse once every (N+1)·2^M reference cycles. It also emits a bit-rate pulse on every sixteenth oversampling pulse. The bit rate is therefore the reference frequency divided by 16·(N+1)·2^M. With a 29.4912 MHz reference, the fastest oversampling rate is one pulse per cycle, which gives a 1,843,200 Hz base bit rate.

Host software loads the divisor with byte-wide writes. A low byte register supplies divisor bits 7:0. The top two bits of a shared control byte supply divisor bits 9:8. A dedicated high-bit write changes only those two bits and leaves the other six control bits untouched. A divisor written while the generator runs is adopted only when the current division period ends, so no shortened period appears. An M = 0 setting is flagged because it is unreliable at reference clocks above 10 MHz.

Top module: `brg_top`

## Requirements
- R1: While rst_n is low at a rising edge (synchronous, active low), the low byte and the control byte clear to 0. Both pulse outputs are 0 after that edge, and m_zero_warn reads 1.
- R2: While pwr_en is high, os_tick pulses once every P = (N+1)·2^M cycles. Here N = div_word[5:0] and M = div_word[9:6] of the divisor in use. After counting restarts, the first pulse appears P cycles later.
- R3: bit_tick is high only together with os_tick, and exactly on every sixteenth os_tick counted from a restart.
- R4: div_word is {ctl_byte[7:6], low byte}. Write code wr_op = 1 loads wr_data into the low byte. Code 2 copies wr_data[7:6] into ctl_byte[7:6].
- R5: Code 3 writes all eight bits of ctl_byte. Code 2 leaves ctl_byte[5:0] unchanged. Codes 0 and 1 leave ctl_byte unchanged.
- R6: The all-zero divisor is legal, and os_tick is then high on every cycle while running.
- R7: m_zero_warn is 1 exactly when div_word[9:6] is 0.
- R8: A divisor written mid-period does not alter the current period. The period that follows the next os_tick uses the new value.
- R9: While pwr_en is low, both pulses stay at 0 and counting restarts. When pwr_en returns high, the programmed divisor is used from the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_en | input | 1 | Run enable; low holds the generator idle |
| wr_op | input | 2 | Write code: 0 none, 1 low byte, 2 divisor high bits, 3 full control byte |
| wr_data | input | 8 | Write data byte |
| os_tick | output | 1 | Oversampling pulse |
| bit_tick | output | 1 | Bit-rate pulse |
| div_word | output | 10 | Programmed divisor {M, N} |
| ctl_byte | output | 8 | Control byte contents |
| m_zero_warn | output | 1 | Programmed exponent is zero |

## Verification
A wrong count in the mantissa or power stage shows as an os_tick that arrives early or late, within one period of the fault. A wrong divide-by-16 counter shows as a misplaced bit_tick within sixteen periods. An early divisor hand-over shows as a gap that matches neither the old nor the new period, in the period during which the write lands. A write that disturbs the shared control byte shows on ctl_byte on the very next cycle. The bench compares every output against a behavioural model every cycle, and also measures gaps between ticks around mid-period writes and power cycling.

// File: rtl/brg_pkg.sv
// Shared constants and the write-code type of the baud rate generator.
package brg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_LO   = 2'd1,
        OP_HI   = 2'd2,
        OP_CTL  = 2'd3
    } wr_op_e;
endpackage

// File: rtl/brg_regs.sv
// Divisor register file: a low byte and a shared control byte whose top bits
// carry the upper divisor bits. Assumes one write code per cycle.
module brg_regs
    import brg_pkg::*;
#(
    parameter int DIV_W = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          wr_op,
    input  logic [BYTE_W-1:0]   wr_data,
    output logic [BYTE_W-1:0]   ctl_q,
    output logic [DIV_W-1:0]    div_word
);
    localparam int HI_W  = DIV_W - BYTE_W;
    localparam int LOW_W = BYTE_W - HI_W;

    logic [BYTE_W-1:0] lo_q;
    wr_op_e            op;

    assign op = wr_op_e'(wr_op);

    // Register update for the three write codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q  <= '0;
            ctl_q <= '0;
        end else begin
            case (op)
                OP_LO:   lo_q <= wr_data;
                OP_HI:   ctl_q[BYTE_W-1 -: HI_W] <= wr_data[BYTE_W-1 -: HI_W];
                OP_CTL:  ctl_q <= wr_data;
                default: ;
            endcase
        end
    end

    // Divisor word assembly from both registers.
    assign div_word = {ctl_q[BYTE_W-1 -: HI_W], lo_q};

    a_r5_hi_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op == 2'd2 |=> ctl_q[LOW_W-1:0] == $past(ctl_q[LOW_W-1:0]));
    a_r5_lo_keeps_ctl: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op == 2'd1 |=> $stable(ctl_q));
    a_r4_lo_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_op == 2'd1 |=> div_word[BYTE_W-1:0] == $past(wr_data));
endmodule

// File: rtl/brg_prescale.sv
// Mantissa/exponent prescaler: a power-of-two stage feeding a mantissa stage,
// giving one pulse per (N+1)*2^M cycles. The divisor in use is replaced only
// at terminal count, or freely while idle.
module brg_prescale #(
    parameter int MANT_W = 6,
    parameter int EXP_W  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic [MANT_W+EXP_W-1:0]   div_word,
    output logic                      os_tick,
    output logic                      fire
);
    localparam int DIV_W  = MANT_W + EXP_W;
    localparam int PCNT_W = (1 << EXP_W) - 1;

    logic [DIV_W-1:0]  act_q;
    logic [MANT_W-1:0] mcnt_q;
    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] pmask;
    logic              p_wrap;
    logic              term;

    // Terminal detection for both stages from the divisor in use.
    always_comb begin
        pmask  = PCNT_W'((64'd1 << act_q[DIV_W-1:MANT_W]) - 64'd1);
        p_wrap = (pcnt_q == pmask);
        term   = p_wrap && (mcnt_q == act_q[MANT_W-1:0]);
    end

    assign fire = run && term;

    // Counter stepping, pulse register and divisor hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q   <= '0;
            mcnt_q  <= '0;
            pcnt_q  <= '0;
            os_tick <= 1'b0;
        end else if (!run) begin
            act_q   <= div_word;
            mcnt_q  <= '0;
            pcnt_q  <= '0;
            os_tick <= 1'b0;
        end else begin
            os_tick <= term;
            pcnt_q  <= p_wrap ? '0 : pcnt_q + 1'b1;
            if (term) begin
                mcnt_q <= '0;
                act_q  <= div_word;
            end else if (p_wrap) begin
                mcnt_q <= mcnt_q + 1'b1;
            end
        end
    end

    a_r8_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
        run && !term |=> $stable(act_q));
    a_r2_count_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt_q <= pmask && mcnt_q <= act_q[MANT_W-1:0]);
endmodule

// File: rtl/brg_tick16.sv
// Divides the oversampling pulse by RATIO to give the bit-rate pulse.
// Assumes fire is a single-cycle qualifier from the prescaler.
module brg_tick16 #(
    parameter int RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic fire,
    output logic bit_tick
);
    localparam int CW = $clog2(RATIO);

    logic [CW-1:0] cnt_q;
    logic          last;

    assign last = (cnt_q == CW'(RATIO - 1));

    // Count oversampling pulses and mark each RATIO-th one.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt_q    <= '0;
            bit_tick <= 1'b0;
        end else begin
            bit_tick <= fire && last;
            if (fire) cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end

    a_r3_bit_from_fire: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> $past(fire));
endmodule

// File: rtl/brg_top.sv
// Baud rate generator top: register file, prescaler and bit-rate divider.
// Assumes a single reference clock domain and a synchronous active-low reset.
module brg_top
    import brg_pkg::*;
#(
    parameter int MANT_W   = 6,
    parameter int EXP_W    = 4,
    parameter int OS_RATIO = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pwr_en,
    input  logic [1:0]                wr_op,
    input  logic [7:0]                wr_data,
    output logic                      os_tick,
    output logic                      bit_tick,
    output logic [MANT_W+EXP_W-1:0]   div_word,
    output logic [7:0]                ctl_byte,
    output logic                      m_zero_warn
);
    localparam int DIV_W = MANT_W + EXP_W;

    logic fire;

    brg_regs #(.DIV_W(DIV_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_op    (wr_op),
        .wr_data  (wr_data),
        .ctl_q    (ctl_byte),
        .div_word (div_word)
    );

    brg_prescale #(.MANT_W(MANT_W), .EXP_W(EXP_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pwr_en),
        .div_word (div_word),
        .os_tick  (os_tick),
        .fire     (fire)
    );

    brg_tick16 #(.RATIO(OS_RATIO)) u_bit (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (pwr_en),
        .fire     (fire),
        .bit_tick (bit_tick)
    );

    // Exponent-zero warning from the programmed divisor.
    assign m_zero_warn = (div_word[DIV_W-1:MANT_W] == '0);

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_en |=> !os_tick && !bit_tick);
    a_r3_bit_with_os: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
endmodule

// File: tb/tb_brg_top.sv
module tb_brg_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_en = 1'b0;
    logic [1:0] wr_op = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       os_tick, bit_tick, m_zero_warn;
    logic [9:0] div_word;
    logic [7:0] ctl_byte;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 0;

    // behavioural model state
    int       m_cnt = 0;
    int       m_c16 = 0;
    bit       e_os = 0, e_bit = 0;
    bit [7:0] m_lo = 0, m_ctl = 0;
    bit [9:0] m_act = 0;

    brg_top dut (
        .clk(clk), .rst_n(rst_n), .pwr_en(pwr_en), .wr_op(wr_op),
        .wr_data(wr_data), .os_tick(os_tick), .bit_tick(bit_tick),
        .div_word(div_word), .ctl_byte(ctl_byte), .m_zero_warn(m_zero_warn)
    );

    always #2.5 clk = ~clk;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Reference model: one behavioural step per rising edge.
    always @(posedge clk) begin
        bit [9:0] old_prog;
        int per;
        cyc++;
        old_prog = {m_ctl[7:6], m_lo};
        if (!rst_n) begin
            m_lo = 0; m_ctl = 0; m_cnt = 0; m_c16 = 0; e_os = 0; e_bit = 0; m_act = 0;
        end else begin
            case (wr_op)
                2'd1: m_lo = wr_data;
                2'd2: m_ctl = {wr_data[7:6], m_ctl[5:0]};
                2'd3: m_ctl = wr_data;
                default: ;
            endcase
            if (!pwr_en) begin
                m_cnt = 0; m_c16 = 0; e_os = 0; e_bit = 0; m_act = old_prog;
            end else begin
                per = (int'(m_act[5:0]) + 1) << m_act[9:6];
                if (m_cnt == per - 1) begin
                    e_os = 1; e_bit = (m_c16 == 15);
                    m_c16 = (m_c16 + 1) % 16; m_cnt = 0; m_act = old_prog;
                end else begin
                    e_os = 0; e_bit = 0; m_cnt++;
                end
            end
        end
        if (cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d expected 0 hung cycles", cyc);
            finish_up();
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (cyc > 0) begin
            check("R2 os_tick", os_tick, e_os);
            check("R3 bit_tick", bit_tick, e_bit);
            check("R4 div_word", div_word, {m_ctl[7:6], m_lo});
            check("R5 ctl_byte", ctl_byte, m_ctl);
            check("R7 m_zero_warn", m_zero_warn, (m_ctl[7:6] == 0 && m_lo[7:6] == 0));
        end
    end

    task automatic wr(input logic [1:0] op, input logic [7:0] d);
        @(negedge clk); #1 wr_op = op; wr_data = d;
        @(negedge clk); #1 wr_op = 2'd0; wr_data = 8'd0;
    endtask

    task automatic wait_tick(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (!os_tick && n < 100000);
    endtask

    initial begin
        int n, n2, seen, bits;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 os_tick reset", os_tick, 0);
        check("R1 bit_tick reset", bit_tick, 0);
        check("R1 div_word reset", div_word, 0);
        check("R1 warn reset", m_zero_warn, 1);
        #1 rst_n = 1;
        // R5: full control write, then high-bit write keeps low six bits
        wr(2'd3, 8'h15);
        wr(2'd1, 8'h03);
        wr(2'd2, 8'h40);
        @(negedge clk);
        check("R5 ctl after hi write", ctl_byte, 8'h55);
        check("R4 div_word N=3 M=4", div_word, 10'h103);
        check("R7 warn off", m_zero_warn, 0);
        // R2/R3 run P=64 for 16 periods
        #1 pwr_en = 1;
        seen = 0; bits = 0;
        for (int i = 0; i < 64 * 16; i++) begin
            @(negedge clk);
            seen += os_tick; bits += bit_tick;
        end
        check("R2 os ticks in 16 periods", seen, 16);
        check("R3 bit ticks in 16 periods", bits, 1);
        // R8: switch to P=6 then write P=4 mid-period
        wr(2'd1, 8'h42);
        wr(2'd2, 8'h00);
        wait_tick(n); wait_tick(n);
        wait_tick(n);
        check("R2 gap P=6", n, 6);
        #1 wr_op = 2'd1; wr_data = 8'h80;
        @(negedge clk); #1 wr_op = 2'd0;
        wait_tick(n);
        check("R8 old period kept", n + 1, 6);
        wait_tick(n2);
        check("R8 new period used", n2, 4);
        // R9: power down, quiet, restart
        #1 pwr_en = 0;
        seen = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); seen += os_tick + bit_tick; end
        check("R9 no ticks while off", seen, 0);
        #1 pwr_en = 1;
        wait_tick(n);
        check("R9 first tick after restart", n, 4);
        // R6: zero divisor
        wr(2'd1, 8'h00);
        repeat (8) @(negedge clk);
        seen = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); seen += os_tick; end
        check("R6 tick every cycle", seen, 40);
        check("R7 warn on zero exponent", m_zero_warn, 1);
        // mixed traffic, compared by the model each cycle
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk); #1;
            case ($urandom % 16)
                0: begin wr_op = 2'd1; wr_data = 8'($urandom); end
                1: begin wr_op = 2'd2; wr_data = 8'($urandom) & 8'h7F; end
                2: begin wr_op = 2'd3; wr_data = 8'($urandom) & 8'h7F; end
                3: pwr_en = ($urandom % 4) != 0;
                default: wr_op = 2'd0;
            endcase
        end
        #1 wr_op = 2'd0; rst_n = 0;
        @(negedge clk); @(negedge clk);
        check("R1 div_word after late reset", div_word, 0);
        check("R1 os_tick after late reset", os_tick, 0);
        finish_up();
    end
endmodule